// File: doc/BRIEF.md
# I2C Master Interrupt Status and Mask Unit

This unit gathers the event pulses produced by an I2C master's bit engine and turns them into one level interrupt for the host. There are four events: transaction complete, address/data acknowledge error, high-speed master-code NACK error and restart-transfer done. Each one sets its own sticky bit in a 16-bit status register. A mask register selects which status bits may drive the interrupt line. The line is the registered OR of status AND mask.

The host reaches the unit over a plain word-wide register port. The port has a write strobe, a read strobe, a byte offset, write data and registered read data. Software clears status bits by writing ones, so a value read from the status register can be written straight back to acknowledge those events. Two more command words are decoded. One is a soft reset that empties the status register. The other drives a one-cycle clear strobe to the bit engine's FIFO address pointers. The reset input is asynchronous active-low. Its release is synchronised to the clock before it reaches the registers, so the unit leaves reset two clock edges after the input is deasserted.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status register, the mask register, `irq`, `fifo_clr` and `rdata` are all zero.
- R2: A one-cycle pulse on `evt_pulse[0]` (transaction complete) sets status bit 0. A pulse on `evt_pulse[1]` (ACK error) sets bit 1, one on `evt_pulse[2]` (high-speed NACK) sets bit 2, and one on `evt_pulse[3]` (restart done) sets bit 4. Each bit stays set until it is cleared. The status register is read at offset 0x0C.
- R3: The mask register is written and read at offset 0x08. Only bits 0, 1, 2 and 4 are stored. Every other bit of the mask and status registers reads as zero.
- R4: A write to offset 0x0C clears each status bit whose write-data bit is 1 and leaves each bit whose write-data bit is 0 unchanged.
- R5: If an event pulse arrives in the same cycle as a write-one-to-clear of its status bit, the bit remains set.
- R6: `irq` is high exactly when some status bit and the same mask bit are both 1. `irq` changes one clock after the status or mask register changes.
- R7: An ACK error followed later by a completion sets bit 1 first and bit 0 afterwards. If software clears the error in between, the line falls, and the completion raises it again as a separate event.
- R8: Writing 0x0001 to offset 0x50 clears all status bits and leaves the mask unchanged. This soft reset takes precedence over an event in the same cycle. Any other value written to 0x50 has no effect.
- R9: Writing 0x0001 to offset 0x38 makes `fifo_clr` high for exactly the one cycle after the write. Any other value written there produces no pulse.
- R10: `rdata` is loaded one clock after a cycle with `rd_en` high and holds its value while `rd_en` is low. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| evt_pulse | input | 4 | Event pulses: complete, ACK error, HS NACK, restart done |
| irq | output | 1 | Level interrupt to the host |
| fifo_clr | output | 1 | One-cycle FIFO address clear strobe |

## Verification
The bench builds the unit with its default parameters: a 16-bit data word and an 8-bit offset. These defaults put all four fixed command offsets and every status bit position within reach. The bench drives event and clear collisions cycle by cycle, and it checks the one-clock lag of the interrupt line against each status change. It repeats the error-then-completion ordering both with and without software clearing the error in between. It confirms that soft reset wins over a coincident event and that wrong command values are ignored.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;

  localparam int unsigned NUM_SRC  = 4;
  localparam int unsigned OFS_MASK = 'h08;
  localparam int unsigned OFS_STAT = 'h0C;
  localparam int unsigned OFS_FIFO = 'h38;
  localparam int unsigned OFS_SRST = 'h50;
  localparam int unsigned CMD_FIRE = 1;

  typedef struct packed {
    logic mask_wr;
    logic stat_wr;
    logic fifo_fire;
    logic soft_rst;
  } reg_cmd_t;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_STAT = 2'd2
  } rd_sel_e;

  // Status bit position of event source idx: sources 0..2 map straight, later ones skip bit 3
  function automatic int unsigned src_pos(input int unsigned idx);
    return (idx < 3) ? idx : idx + 1;
  endfunction

  // Event source that owns status bit pos, or -1 for an unimplemented bit
  function automatic int pos_src(input int unsigned pos);
    int r;
    if (pos < 3) r = int'(pos);
    else if (pos == 3) r = -1;
    else r = int'(pos) - 1;
    if (r >= int'(NUM_SRC)) r = -1;
    return r;
  endfunction

  function automatic logic [31:0] impl_word(input int unsigned nsrc);
    logic [31:0] w;
    w = '0;
    for (int unsigned i = 0; i < nsrc; i++) w[src_pos(i)] = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_unit_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output reg_cmd_t          cmd,
  output rd_sel_e           rd_sel
);
  logic hit_mask, hit_stat, hit_fifo, hit_srst, is_fire;

  always_comb begin
    hit_mask = (addr == ADDR_W'(OFS_MASK));
    hit_stat = (addr == ADDR_W'(OFS_STAT));
    hit_fifo = (addr == ADDR_W'(OFS_FIFO));
    hit_srst = (addr == ADDR_W'(OFS_SRST));
    is_fire  = (wdata == DATA_W'(CMD_FIRE));

    cmd.mask_wr   = wr_en && hit_mask;
    cmd.stat_wr   = wr_en && hit_stat;
    cmd.fifo_fire = wr_en && hit_fifo && is_fire;
    cmd.soft_rst  = wr_en && hit_srst && is_fire;

    if (hit_mask)      rd_sel = SEL_MASK;
    else if (hit_stat) rd_sel = SEL_STAT;
    else               rd_sel = SEL_NONE;
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_unit_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  reg_cmd_t           cmd,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  stat_q,
  output logic [DATA_W-1:0]  mask_q
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    localparam int SRC = pos_src(g);
    if (SRC >= 0) begin : g_impl
      logic s_q, s_d, m_q, m_d, m_en;

      always_comb begin
        if (cmd.soft_rst) s_d = 1'b0;
        else              s_d = evt[SRC] | (s_q & ~(cmd.stat_wr & wdata[g]));
        m_en = cmd.mask_wr;
        m_d  = wdata[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b0;
        else        s_q <= s_d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    m_q <= 1'b0;
        else if (m_en) m_q <= m_d;
      end

      assign stat_q[g] = s_q;
      assign mask_q[g] = m_q;
    end else begin : g_none
      assign stat_q[g] = 1'b0;
      assign mask_q[g] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage
  import irq_unit_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  rd_sel_e           rd_sel,
  input  logic [DATA_W-1:0] stat_q,
  input  logic [DATA_W-1:0] mask_q,
  input  logic              fifo_fire,
  output logic              irq,
  output logic              fifo_clr,
  output logic [DATA_W-1:0] rdata
);
  logic              irq_d, fifo_d, rd_ld;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    irq_d  = |(stat_q & mask_q);
    fifo_d = fifo_fire;
    rd_ld  = rd_en;
    case (rd_sel)
      SEL_MASK: rdata_d = mask_q;
      SEL_STAT: rdata_d = stat_q;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq      <= 1'b0;
      fifo_clr <= 1'b0;
    end else begin
      irq      <= irq_d;
      fifo_clr <= fifo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_ld) rdata <= rdata_d;
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_unit_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NUM_SRC-1:0] evt_pulse,
  output logic               irq,
  output logic               fifo_clr
);
  logic              rst_core_n;
  reg_cmd_t          cmd;
  rd_sel_e           rd_sel;
  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] mask_q;

  irq_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  irq_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_decode (
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .cmd    (cmd),
    .rd_sel (rd_sel)
  );

  irq_status_bank #(.DATA_W(DATA_W)) i_bank (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .evt    (evt_pulse),
    .cmd    (cmd),
    .wdata  (wdata),
    .stat_q (stat_q),
    .mask_q (mask_q)
  );

  irq_out_stage #(.DATA_W(DATA_W)) i_out (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .rd_en     (rd_en),
    .rd_sel    (rd_sel),
    .stat_q    (stat_q),
    .mask_q    (mask_q),
    .fifo_fire (cmd.fifo_fire),
    .irq       (irq),
    .fifo_clr  (fifo_clr),
    .rdata     (rdata)
  );
endmodule

// File: rtl/irq_unit_checker.sv
module irq_unit_checker
  import irq_unit_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wdata,
  input logic [NUM_SRC-1:0] evt,
  input logic [DATA_W-1:0]  stat,
  input logic [DATA_W-1:0]  mask,
  input logic               irq,
  input logic               fifo_clr,
  input logic [DATA_W-1:0]  rdata
);
  localparam logic [DATA_W-1:0] IMPL = DATA_W'(impl_word(NUM_SRC));

  logic stat_w, srst_w, fifo_w;
  assign stat_w = wr_en && (addr == ADDR_W'(OFS_STAT));
  assign srst_w = wr_en && (addr == ADDR_W'(OFS_SRST)) && (wdata == DATA_W'(CMD_FIRE));
  assign fifo_w = wr_en && (addr == ADDR_W'(OFS_FIFO)) && (wdata == DATA_W'(CMD_FIRE));

  AST_EVT0_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[0] && !srst_w) |=> stat[0]);  // R2
  AST_EVT1_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[1] && !srst_w) |=> stat[1]);  // R2
  AST_EVT2_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[2] && !srst_w) |=> stat[2]);  // R2
  AST_EVT3_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[3] && !srst_w) |=> stat[4]);  // R2
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdata & ~IMPL) == '0));  // R3
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_w && wdata[1] && !evt[1]) |=> !stat[1]);  // R4
  AST_W0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_w && !wdata[0] && stat[0] && !srst_w) |=> stat[0]);  // R4
  AST_COLLIDE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_w && wdata[0] && evt[0]) |=> stat[0]);  // R5
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|(stat & mask)));  // R6
  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    srst_w |=> (stat == '0));  // R8
  AST_SRST_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    srst_w |=> $stable(mask));  // R8
  AST_FIFO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |-> $past(fifo_w));  // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));  // R10
endmodule

bind irq_status_unit irq_unit_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .wdata    (wdata),
  .evt      (evt_pulse),
  .stat     (stat_q),
  .mask     (mask_q),
  .irq      (irq),
  .fifo_clr (fifo_clr),
  .rdata    (rdata)
);

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_MASK = 8'h08, A_STAT = 8'h0C, A_FIFO = 8'h38, A_SRST = 8'h50;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [3:0]  evt_pulse;
  logic        irq, fifo_clr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_unit i_irq_status_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_pulse(evt_pulse), .irq(irq), .fifo_clr(fifo_clr)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic reg_write(input logic [7:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input int idx);
    evt_pulse = 4'b0001 << idx;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R1 irq", {15'd0, irq}, 16'h0);
    check("R1 fifo_clr", {15'd0, fifo_clr}, 16'h0);
    check("R1 rdata", rdata, 16'h0);
    reg_read(A_STAT, v); check("R1 status", v, 16'h0);
    reg_read(A_MASK, v); check("R1 mask", v, 16'h0);
  endtask

  task automatic t_sources;
    logic [15:0] v;
    int pos [4] = '{0, 1, 2, 4};
    for (int i = 0; i < 4; i++) begin
      pulse(i);
      repeat (2) @(negedge clk);
      reg_read(A_STAT, v); check("R2 source bit", v, 16'h1 << pos[i]);
      reg_write(A_STAT, 16'h1 << pos[i]);
    end
    reg_read(A_STAT, v); check("R2 all cleared", v, 16'h0);
  endtask

  task automatic t_mask;
    logic [15:0] v;
    reg_write(A_MASK, 16'hFFFF);
    reg_read(A_MASK, v); check("R3 mask implemented bits", v, 16'h0017);
    reg_write(A_MASK, 16'h0012);
    reg_read(A_MASK, v); check("R3 mask pattern", v, 16'h0012);
    reg_write(A_MASK, 16'h0000);
  endtask

  task automatic t_w1c;
    logic [15:0] v;
    pulse(0); pulse(1); pulse(2);
    reg_write(A_STAT, 16'h0002);
    reg_read(A_STAT, v); check("R4 clear one bit", v, 16'h0005);
    reg_write(A_STAT, 16'h0000);
    reg_read(A_STAT, v); check("R4 zero write keeps", v, 16'h0005);
    reg_write(A_STAT, 16'hFFFF);
    reg_read(A_STAT, v); check("R4 clear all", v, 16'h0000);
  endtask

  task automatic t_collide;
    logic [15:0] v;
    pulse(0);
    evt_pulse = 4'b0001; wr_en = 1'b1; addr = A_STAT; wdata = 16'h0001;
    @(negedge clk);
    evt_pulse = '0; wr_en = 1'b0;
    reg_read(A_STAT, v); check("R5 event beats clear", v, 16'h0001);
    reg_write(A_STAT, 16'h0001);
    reg_read(A_STAT, v); check("R5 later clear works", v, 16'h0000);
  endtask

  task automatic t_irq;
    logic [15:0] v;
    reg_write(A_MASK, 16'h0001);
    pulse(1);
    @(negedge clk);
    check("R6 masked source no irq", {15'd0, irq}, 16'h0);
    pulse(0);
    check("R6 irq lags status", {15'd0, irq}, 16'h0);
    @(negedge clk);
    check("R6 irq raised", {15'd0, irq}, 16'h1);
    reg_write(A_STAT, 16'h0001);
    check("R6 irq still high one cycle", {15'd0, irq}, 16'h1);
    @(negedge clk);
    check("R6 irq dropped", {15'd0, irq}, 16'h0);
    reg_write(A_MASK, 16'h0003);
    @(negedge clk);
    check("R6 unmask pending bit", {15'd0, irq}, 16'h1);
    reg_write(A_STAT, 16'hFFFF);
    @(negedge clk);
    reg_read(A_STAT, v); check("R6 status empty", v, 16'h0);
  endtask

  task automatic t_ackerr;
    logic [15:0] v;
    pulse(1); @(negedge clk);
    check("R7 error raises irq", {15'd0, irq}, 16'h1);
    reg_read(A_STAT, v); check("R7 error first", v, 16'h0002);
    reg_write(A_STAT, v); @(negedge clk);
    check("R7 irq falls after ack", {15'd0, irq}, 16'h0);
    pulse(0); @(negedge clk);
    check("R7 completion raises again", {15'd0, irq}, 16'h1);
    reg_read(A_STAT, v); check("R7 completion second", v, 16'h0001);
    reg_write(A_STAT, v);
    pulse(1);
    reg_read(A_STAT, v); check("R7 only error before completion", v, 16'h0002);
    pulse(0);
    reg_read(A_STAT, v); check("R7 both kept", v, 16'h0003);
    reg_write(A_STAT, v);
  endtask

  task automatic t_srst;
    logic [15:0] v;
    pulse(0); pulse(3);
    reg_write(A_SRST, 16'h0002);
    reg_read(A_STAT, v); check("R8 wrong value ignored", v, 16'h0011);
    reg_write(A_SRST, 16'h0001);
    reg_read(A_STAT, v); check("R8 soft reset clears", v, 16'h0000);
    reg_read(A_MASK, v); check("R8 mask kept", v, 16'h0003);
    evt_pulse = 4'b0010; wr_en = 1'b1; addr = A_SRST; wdata = 16'h0001;
    @(negedge clk);
    evt_pulse = '0; wr_en = 1'b0;
    reg_read(A_STAT, v); check("R8 soft reset beats event", v, 16'h0000);
    reg_write(A_MASK, 16'h0000);
  endtask

  task automatic t_fifo;
    reg_write(A_FIFO, 16'h0001);
    check("R9 pulse high", {15'd0, fifo_clr}, 16'h1);
    @(negedge clk);
    check("R9 pulse one cycle", {15'd0, fifo_clr}, 16'h0);
    reg_write(A_FIFO, 16'h0003);
    check("R9 wrong value no pulse", {15'd0, fifo_clr}, 16'h0);
  endtask

  task automatic t_read;
    logic [15:0] v;
    pulse(2);
    reg_read(A_STAT, v); check("R10 read status", v, 16'h0004);
    pulse(0);
    repeat (2) @(negedge clk);
    check("R10 rdata holds", rdata, 16'h0004);
    reg_read(8'h04, v); check("R10 unmapped offset", v, 16'h0000);
    reg_read(A_SRST, v); check("R10 command offset reads zero", v, 16'h0000);
    reg_write(A_STAT, 16'hFFFF);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; evt_pulse = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_sources();
    t_mask();
    t_w1c();
    t_collide();
    t_irq();
    t_ackerr();
    t_srst();
    t_fifo();
    t_read();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule